// File: doc/BRIEF.md
# Sliding-Window Energy Threshold Marker

This block classifies a linear stream of instructions into high-power and low-power regions. Each input beat carries one instruction's normalized energy weight; the cheapest instruction weighs 1 and a wide vector multiply-add weighs close to 100. For every instruction the block forms a look-ahead window made of that instruction and the K−1 instructions behind it, keeps the window total as a running sum, and compares the total with a programmable threshold. An instruction is emitted once its window is complete. It carries a 2-bit mark: 01 where a high-power region opens, 10 where the stream may drop back to low power, 00 elsewhere.

A window that reaches the threshold opens a high region at its first instruction. It then puts the next K−1 instructions into a quiet shadow, where no mark may appear and any pending low mark is withdrawn. It schedules a low mark K instructions after itself. A later threshold window inside the shadow re-arms both the shadow and the low mark. A low mark that lands on an instruction which itself meets the threshold becomes a high mark. Instructions are processed strictly in stream order. The final beat of a path is flagged. The block then drains the instructions it still holds without further input. A window that would extend past the path end never meets the threshold. Nothing pending crosses into the next path.

Both streams use valid/ready. A beat moves on a clock edge where valid and ready are both high. The output holds its weight, mark and last flag steady while valid is high and ready is low. Input ready depends combinationally on output ready: with K instructions held, a new weight is accepted only in a cycle where the oldest one leaves. The window length and threshold are plain configuration inputs. They may change only while the block holds no instructions.

Top module: `ewm_marker`

## Requirements
- R1: Every accepted weight appears exactly once on the output, unchanged and in acceptance order, and the last-beat flag comes out on the final instruction of each path.
- R2: Outside a drain, an instruction becomes valid on the output in the cycle after its (K−1)-th successor is accepted, and the block never holds more than K instructions.
- R3: An instruction whose complete K-instruction window sum is greater than or equal to the threshold, and which is not in a shadow, gets mark 01.
- R4: The K−1 instructions after any threshold instruction carry mark 00, even when they meet the threshold themselves; such an instruction restarts the shadow and the pending low mark.
- R5: The instruction exactly K positions after the latest threshold instruction gets mark 10, or mark 01 when its own window meets the threshold.
- R6: A window sum below the threshold, with no pending low mark due, gives mark 00; a sum equal to the threshold counts as meeting it.
- R7: After a beat flagged last is accepted, input ready stays low while the held instructions drain; a window cut short by the path end never meets the threshold; a low mark due past the path end is dropped, and the next path starts with no shadow and no pending mark.
- R8: While output valid is high and output ready is low, weight, mark and last flag hold steady, and with K instructions held input ready is low.
- R9: An active-low reset, at any time, empties the block: output valid goes low, input ready goes high, and no earlier instruction is emitted afterwards.
- R10: Mark code 11 never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_k | input | 10 | Window length K, 1 to 512 |
| cfg_th | input | 24 | Energy threshold |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_weight | input | 8 | Instruction energy weight |
| in_last | input | 1 | Beat is the final instruction of the path |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_weight | output | 8 | Weight of the emitted instruction |
| out_label | output | 2 | Mark: 00 none, 01 high start, 10 low start |
| out_last | output | 1 | Emitted instruction ends the path |

## Verification
Output signals are combinational from registered state, so a weight accepted at an edge affects out_valid and out_label right after that edge. Instruction i shows up one cycle after the edge that accepts its (K−1)-th successor; in the drain, one instruction leaves per accepted output beat. The bench drives inputs on the falling edge and reads the outputs one time unit later. It counts a transfer only when valid and ready are both seen high at that moment. Expected marks are worked out by hand for each path and checked in stream order, whatever stalls occur.

// File: rtl/ewm_pkg.sv
package ewm_pkg;
  typedef enum logic [1:0] {
    LBL_NONE = 2'b00,
    LBL_HIGH = 2'b01,
    LBL_LOW  = 2'b10
  } lbl_e;
endpackage

// File: rtl/ewm_window_buf.sv
// Circular delay store: holds the instructions whose windows are still open.
module ewm_window_buf #(
  parameter int WT_W  = 8,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [WT_W-1:0] push_data,
  input  logic            pop,
  output logic [WT_W-1:0] head_data,
  output logic [CW-1:0]   count
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WT_W-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/ewm_run_sum.sv
// Running window total: adds the entering weight, subtracts the leaving one.
module ewm_run_sum #(
  parameter int WT_W  = 8,
  parameter int SUM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [WT_W-1:0]  add_val,
  input  logic             sub_en,
  input  logic [WT_W-1:0]  sub_val,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] add_ext, sub_ext;

  always_comb begin
    add_ext = add_en ? SUM_W'(add_val) : '0;
    sub_ext = sub_en ? SUM_W'(sub_val) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= '0;
    else        sum <= sum + add_ext - sub_ext;
  end
endmodule

// File: rtl/ewm_label_seq.sv
// Mark sequencer: one shadow countdown plus a pending-low flag.
module ewm_label_seq
  import ewm_pkg::*;
#(
  parameter int K_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           path_done,
  input  logic           win_full,
  input  logic           over_th,
  input  logic [K_W-1:0] k_len,
  output lbl_e           label
);
  logic [K_W-1:0] shadow_left;
  logic           low_pend;
  logic           trig, in_shadow;

  always_comb begin
    trig      = win_full && over_th;
    in_shadow = (shadow_left != '0);
    if (in_shadow)     label = LBL_NONE;
    else if (trig)     label = LBL_HIGH;
    else if (low_pend) label = LBL_LOW;
    else               label = LBL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_left <= '0;
      low_pend    <= 1'b0;
    end else if (step) begin
      if (path_done) begin
        shadow_left <= '0;
        low_pend    <= 1'b0;
      end else if (trig) begin
        shadow_left <= k_len - 1'b1;
        low_pend    <= 1'b1;
      end else if (in_shadow) begin
        shadow_left <= shadow_left - 1'b1;
      end else begin
        low_pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ewm_marker.sv
module ewm_marker
  import ewm_pkg::*;
#(
  parameter int WT_W  = 8,
  parameter int KMAX  = 512,
  parameter int SUM_W = 24,
  localparam int K_W  = $clog2(KMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K_W-1:0]   cfg_k,
  input  logic [SUM_W-1:0] cfg_th,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WT_W-1:0]  in_weight,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WT_W-1:0]  out_weight,
  output logic [1:0]       out_label,
  output logic             out_last
);
  logic             draining;
  logic [K_W-1:0]   held;
  logic [WT_W-1:0]  head_w;
  logic [SUM_W-1:0] win_sum;
  logic             win_full, push, pop, path_done;
  lbl_e             lbl;

  always_comb begin
    win_full  = (held == cfg_k);
    out_valid = win_full || (draining && held != '0);
    pop       = out_valid && out_ready;
    in_ready  = !draining && ((held < cfg_k) || (win_full && out_ready));
    push      = in_valid && in_ready;
    out_last  = draining && (held == K_W'(1));
    path_done = pop && out_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                draining <= 1'b0;
    else if (push && in_last)  draining <= 1'b1;
    else if (path_done)        draining <= 1'b0;
  end

  ewm_window_buf #(.WT_W(WT_W), .DEPTH(KMAX)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_weight),
    .pop(pop), .head_data(head_w), .count(held)
  );

  ewm_run_sum #(.WT_W(WT_W), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .add_en(push), .add_val(in_weight),
    .sub_en(pop), .sub_val(head_w), .sum(win_sum)
  );

  ewm_label_seq #(.K_W(K_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(pop), .path_done(path_done),
    .win_full(win_full), .over_th(win_sum >= cfg_th), .k_len(cfg_k),
    .label(lbl)
  );

  assign out_weight = head_w;
  assign out_label  = lbl;
endmodule

// File: rtl/ewm_marker_chk.sv
module ewm_marker_chk
  import ewm_pkg::*;
#(
  parameter int WT_W = 8,
  parameter int KMAX = 512,
  localparam int K_W = $clog2(KMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [K_W-1:0]  cfg_k,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_last,
  input logic            out_valid,
  input logic            out_ready,
  input logic [WT_W-1:0] out_weight,
  input logic [1:0]      out_label,
  input logic            out_last
);
  logic           in_fire, out_fire;
  logic [K_W:0]   occ, since_plus;
  logic           flushing, high;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ        <= '0;
      flushing   <= 1'b0;
      high       <= 1'b0;
      since_plus <= '0;
    end else begin
      occ <= occ + (K_W+1)'(in_fire) - (K_W+1)'(out_fire);
      if (in_fire && in_last)         flushing <= 1'b1;
      else if (out_fire && out_last)  flushing <= 1'b0;
      if (out_fire) begin
        if (out_last)                   high <= 1'b0;
        else if (out_label == LBL_HIGH) high <= 1'b1;
        else if (out_label == LBL_LOW)  high <= 1'b0;
        if (out_label == LBL_HIGH)      since_plus <= (K_W+1)'(1);
        else if (since_plus != '1)      since_plus <= since_plus + 1'b1;
      end
    end
  end

  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_label != 2'b11);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= {1'b0, cfg_k});

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_weight)
      && $stable(out_label) && $stable(out_last));

  p_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == {1'b0, cfg_k}) && !out_ready |-> !in_ready);

  p_flush_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !in_ready);

  p_low_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_label == LBL_LOW |-> high && since_plus >= {1'b0, cfg_k});

  p_shadow_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && high && since_plus < {1'b0, cfg_k} |-> out_label == LBL_NONE);
endmodule

bind ewm_marker ewm_marker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .in_valid(in_valid),
  .in_ready(in_ready), .in_last(in_last), .out_valid(out_valid),
  .out_ready(out_ready), .out_weight(out_weight), .out_label(out_label),
  .out_last(out_last)
);

// File: tb/sim_ewm_marker.sv
module sim_ewm_marker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  // {k[3:0], th[7:0], last, weight[7:0], expected mark[1:0]}
  localparam logic [22:0] VEC [NV] = '{
    // path A, K=3 TH=10: equal-threshold trigger, shadow re-arm, low mark on last
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd1, 2'd1},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd8, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd1, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd2}, {4'd3, 8'd10, 1'b0, 8'd1, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd1}, {4'd3, 8'd10, 1'b0, 8'd5, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd5, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd5, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b1, 8'd1, 2'd2},
    // path B: low mark replaced by high, pending low dropped at path end
    {4'd3, 8'd10, 1'b0, 8'd4, 2'd1}, {4'd3, 8'd10, 1'b0, 8'd4, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd4, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd1, 2'd1},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd9, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b1, 8'd1, 2'd0},
    // path C: nothing carried over from B
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b0, 8'd1, 2'd0},
    {4'd3, 8'd10, 1'b0, 8'd1, 2'd0}, {4'd3, 8'd10, 1'b1, 8'd1, 2'd0},
    // path D: heavy but cut-short window
    {4'd3, 8'd10, 1'b0, 8'd9, 2'd0}, {4'd3, 8'd10, 1'b1, 8'd9, 2'd0},
    // path E, K=1 TH=5
    {4'd1, 8'd5, 1'b0, 8'd5, 2'd1}, {4'd1, 8'd5, 1'b0, 8'd1, 2'd2},
    {4'd1, 8'd5, 1'b0, 8'd5, 2'd1}, {4'd1, 8'd5, 1'b0, 8'd5, 2'd1},
    {4'd1, 8'd5, 1'b1, 8'd1, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_k = 10'd3;
  logic [23:0] cfg_th = 24'd10;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_weight = 8'd0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_weight;
  logic [1:0]  out_label;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ewm_marker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .cfg_th(cfg_th),
    .in_valid(in_valid), .in_ready(in_ready), .in_weight(in_weight),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_weight(out_weight), .out_label(out_label), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [7:0] w, input logic il, input logic ordy);
    @(negedge clk);
    in_valid = iv; in_weight = w; in_last = il; out_ready = ordy;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // Vector table walk: R1 R3 R4 R5 R6 R7 under gaps and stalls
    begin
      int sent = 0, rcvd = 0, cyc = 0;
      while (rcvd < NV) begin
        logic pstart;
        @(negedge clk);
        pstart = 1'b0;
        if (sent < NV) pstart = (sent == 0) ? 1'b1 : VEC[sent-1][10];
        if (sent < NV && pstart && sent == rcvd) begin
          cfg_k  = {6'd0, VEC[sent][22:19]};
          cfg_th = {16'd0, VEC[sent][18:11]};
        end
        in_valid = (sent < NV) && (!pstart || sent == rcvd) && (cyc % 4 != 2);
        if (sent < NV) begin
          in_weight = VEC[sent][9:2];
          in_last   = VEC[sent][10];
        end
        out_ready = (cyc % 5 != 3);
        #1;
        if (sent > 0 && VEC[sent-1][10] && rcvd < sent)
          check(in_ready == 1'b0, "R7 input blocked while draining", in_ready, 0);
        if (out_valid && out_ready) begin
          check(out_weight == VEC[rcvd][9:2], "R1 weight order", out_weight, VEC[rcvd][9:2]);
          check(out_last == VEC[rcvd][10], "R1 R7 last flag", out_last, VEC[rcvd][10]);
          check(out_label == VEC[rcvd][1:0], "R3 R4 R5 R6 R7 mark", out_label, VEC[rcvd][1:0]);
          rcvd++;
        end
        if (in_valid && in_ready) sent++;
        cyc++;
      end
    end

    // R2 latency with K=4, then R8 back-pressure, then R7 drain
    step(1'b0, 8'd0, 1'b0, 1'b1);
    cfg_k = 10'd4; cfg_th = 24'd200;
    step(1'b1, 8'd10, 1'b0, 1'b1);
    step(1'b1, 8'd20, 1'b0, 1'b1);
    check(out_valid == 1'b0, "R2 not valid after 1", out_valid, 0);
    step(1'b1, 8'd30, 1'b0, 1'b1);
    check(out_valid == 1'b0, "R2 not valid after 2", out_valid, 0);
    step(1'b1, 8'd40, 1'b0, 1'b1);
    check(out_valid == 1'b0, "R2 not valid after 3", out_valid, 0);
    step(1'b1, 8'd50, 1'b1, 1'b0);
    check(out_valid == 1'b1, "R2 valid after K", out_valid, 1);
    check(out_weight == 8'd10, "R2 first weight", out_weight, 10);
    check(out_label == 2'b00, "R6 below threshold", out_label, 0);
    check(in_ready == 1'b0, "R8 full and stalled blocks input", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 8'd50, 1'b1, 1'b0);
      check(out_valid == 1'b1 && out_weight == 8'd10, "R8 held under stall", out_weight, 10);
    end
    step(1'b1, 8'd50, 1'b1, 1'b1);
    check(in_ready == 1'b1, "R8 accept while head leaves", in_ready, 1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 8'd0, 1'b0, 1'b1);
      check(out_weight == 8'(20 + 10 * i), "R1 drain order", out_weight, 20 + 10 * i);
      check(in_ready == 1'b0, "R7 drain blocks input", in_ready, 0);
      check(out_last == (i == 3), "R7 last on final", out_last, (i == 3));
    end
    step(1'b0, 8'd0, 1'b0, 1'b1);
    check(out_valid == 1'b0, "R7 empty after drain", out_valid, 0);

    // R9 reset in mid-path
    cfg_k = 10'd3;
    step(1'b1, 8'd7, 1'b0, 1'b1);
    step(1'b1, 8'd7, 1'b0, 1'b1);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0; #1;
    check(out_valid == 1'b0, "R9 mid-path reset valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 mid-path reset ready", in_ready, 1);
    step(1'b0, 8'd0, 1'b0, 1'b1);
    rst_n = 1'b1;
    step(1'b1, 8'd2, 1'b0, 1'b1);
    step(1'b1, 8'd3, 1'b0, 1'b1);
    step(1'b1, 8'd4, 1'b1, 1'b1);
    step(1'b0, 8'd0, 1'b0, 1'b1);
    check(out_valid && out_weight == 8'd2, "R9 no stale instruction", out_weight, 2);
    repeat (4) step(1'b0, 8'd0, 1'b0, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule